// File: doc/BRIEF.md
# Floating-Point Error Interrupt Controller

This block turns the floating-point unit's error-summary status into a legacy, level-style interrupt request on IRQ13, as interrupt-driven DOS software expects. The request is gated by the numeric-exception-mode bit of the processor control register. When that bit is set, errors are reported natively and the request line stays quiet. When it is clear, a pending error summary raises IRQ13.

Software acknowledges the request with a byte-wide I/O write to port F0h or F1h. That write drops IRQ13 and tells the FPU to ignore numeric errors. The ignore condition ends on its own once the error-summary bit clears, and normal monitoring then resumes. Writes of any other width, and writes to other ports, do not count as an acknowledge. The block has three states: idle, raised and muted. Both outputs are taken straight from flops.

Top module: `fperr_irq_ctrl`

## Requirements
- R1: While `ne_i` is high at a clock edge, `irq13_o` is low after that edge, whatever the other inputs are. If the request was raised, it is withdrawn.
- R2: In the idle state, with `ne_i` low and `es_i` high at a clock edge, `irq13_o` is high after that edge.
- R3: An acknowledge is an `io_wr_i` cycle with `io_size_i` = 2'b00 (byte) and a full 16-bit `io_addr_i` of 16'h00F0 or 16'h00F1.
- R4: An acknowledge sampled while the request is raised (with `ne_i` low and `es_i` high) gives `irq13_o` low and `fpu_ignore_o` high after that edge.
- R5: While muted and `es_i` stays high, `fpu_ignore_o` stays high and `irq13_o` stays low. This holds even if `ne_i` changes or a further acknowledge arrives.
- R6: While muted, `es_i` low at an edge returns the block to idle, with both outputs low after that edge. A later high `es_i` raises the request again. IRQ13 is therefore never raised again until `es_i` has been seen low.
- R7: These writes have no visible effect: a write to 00F0h/00F1h with size 2'b01 (16-bit) or 2'b10 (32-bit), a byte write to any other port, and an acknowledge while idle.
- R8: While `rst_n` is low, and in the first cycles after its synchronised release, both outputs are low and the block is idle.
- R9: If `es_i` goes low while the request is raised and no acknowledge has come, `irq13_o` is low after that edge.
- R10: `irq13_o` and `fpu_ignore_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ne_i | input | 1 | Numeric-exception-mode bit from the control register (1 = native reporting) |
| es_i | input | 1 | Error-summary bit from the FPU status word |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | ADDR_W (16) | I/O port address |
| io_size_i | input | 2 | Write width: 00 byte, 01 16-bit, 10 32-bit |
| irq13_o | output | 1 | Interrupt request, active high level |
| fpu_ignore_o | output | 1 | Tells the FPU to ignore numeric errors |

## Verification
Every result appears exactly one clock edge after the inputs that cause it are sampled, because both outputs are flops fed by the next-state logic. The driver applies one input set per cycle on the falling edge and queues the output pair that set should produce. The monitor pops and compares that pair one time unit after the next rising edge, so each expectation is checked in the single cycle where it is due. Reset is checked separately while it is held and during the synchroniser delay, before the queue is used.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RAISED = 2'd1,
    ST_MUTED  = 2'd2
  } fperr_state_e;

  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_WORD  = 2'b01;
  localparam logic [1:0] SZ_DWORD = 2'b10;

endpackage

// File: rtl/fperr_rst_sync.sv
module fperr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fperr_ack_decode.sv
module fperr_ack_decode
  import fperr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ACK_BASE = 16'h00F0
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              ack_o
);

  // The acknowledge window is a pair of ports: ACK_BASE and ACK_BASE+1.
  localparam int PAIR_W = ADDR_W - 1;
  localparam logic [PAIR_W-1:0] PAIR_TAG = ACK_BASE[ADDR_W-1:1];

  logic port_hit;
  logic byte_wide;

  assign port_hit  = (addr_i[ADDR_W-1:1] == PAIR_TAG);
  assign byte_wide = (size_i == SZ_BYTE);
  assign ack_o     = wr_i && port_hit && byte_wide;

endmodule

// File: rtl/fperr_fsm.sv
module fperr_fsm
  import fperr_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic ne_i,
  input  logic es_i,
  input  logic ack_i,
  output logic irq_o,
  output logic ign_o
);

  fperr_state_e state_q, state_n;
  logic         state_en;
  logic         irq_n, ign_n;

  // Next state: native mode wins, then error clearing, then acknowledge.
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!ne_i && es_i) state_n = ST_RAISED;
      end
      ST_RAISED: begin
        if (ne_i)       state_n = ST_IDLE;
        else if (!es_i) state_n = ST_IDLE;
        else if (ack_i) state_n = ST_MUTED;
      end
      ST_MUTED: begin
        if (!es_i) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign state_en = (state_n != state_q);
  assign irq_n    = (state_n == ST_RAISED);
  assign ign_n    = (state_n == ST_MUTED);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      irq_o   <= 1'b0;
      ign_o   <= 1'b0;
    end else if (state_en) begin
      state_q <= state_n;
      irq_o   <= irq_n;
      ign_o   <= ign_n;
    end
  end

  AST_NATIVE_MASKS: assert property (@(posedge clk) disable iff (!srst_n)
    ne_i |=> !irq_o); // R1

  AST_NO_ES_NO_IRQ: assert property (@(posedge clk) disable iff (!srst_n)
    !es_i |=> !irq_o); // R9

  AST_ACK_MUTES: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_o && ack_i && !ne_i && es_i) |=> (!irq_o && ign_o)); // R4

  AST_MUTE_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (ign_o && es_i) |=> (ign_o && !irq_o)); // R5

  AST_MUTE_EXITS: assert property (@(posedge clk) disable iff (!srst_n)
    (ign_o && !es_i) |=> (!ign_o && !irq_o)); // R6

  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!srst_n)
    (!irq_o && !ign_o && ack_i) |=> !ign_o); // R7

  AST_OUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!srst_n)
    !(irq_o && ign_o)); // R10

endmodule

// File: rtl/fperr_irq_ctrl.sv
module fperr_irq_ctrl
  import fperr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ACK_BASE    = 16'h00F0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ne_i,
  input  logic              es_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [1:0]        io_size_i,
  output logic              irq13_o,
  output logic              fpu_ignore_o
);

  logic srst_n;
  logic ack;

  fperr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fperr_ack_decode #(.ADDR_W(ADDR_W), .ACK_BASE(ACK_BASE)) u_ack_dec (
    .wr_i   (io_wr_i),
    .addr_i (io_addr_i),
    .size_i (io_size_i),
    .ack_o  (ack)
  );

  fperr_fsm u_fsm (
    .clk    (clk),
    .srst_n (srst_n),
    .ne_i   (ne_i),
    .es_i   (es_i),
    .ack_i  (ack),
    .irq_o  (irq13_o),
    .ign_o  (fpu_ignore_o)
  );

endmodule

// File: tb/fperr_irq_ctrl_tb.sv
module fperr_irq_ctrl_tb;

  typedef struct {
    logic  irq;
    logic  ign;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ne, es, wr;
  logic [15:0] addr;
  logic [1:0]  size;
  logic        irq, ign;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  fperr_irq_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ne_i         (ne),
    .es_i         (es),
    .io_wr_i      (wr),
    .io_addr_i    (addr),
    .io_size_i    (size),
    .irq13_o      (irq),
    .fpu_ignore_o (ign)
  );

  task automatic check(input string tag, input logic a_irq, input logic a_ign,
                       input logic e_irq, input logic e_ign);
    n_run++;
    if (a_irq !== e_irq || a_ign !== e_ign) begin
      n_fail++;
      $display("FAIL %s: irq=%b ign=%b expected irq=%b ign=%b", tag, a_irq, a_ign, e_irq, e_ign);
    end
  endtask

  // Driver: one input set per cycle, queued with the outputs it must produce.
  task automatic step(input logic i_ne, input logic i_es, input logic i_wr,
                      input logic [15:0] i_addr, input logic [1:0] i_size,
                      input logic e_irq, input logic e_ign, input string tag);
    exp_t it;
    @(negedge clk);
    ne = i_ne; es = i_es; wr = i_wr; addr = i_addr; size = i_size;
    it.irq = e_irq; it.ign = e_ign; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result is due one edge after sampling.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check(it.tag, irq, ign, it.irq, it.ign);
        n_run++;
        if (irq && ign) begin
          n_fail++;
          $display("FAIL R10: irq=%b ign=%b expected not both high", irq, ign);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ne = 1'b0; es = 1'b1; wr = 1'b0; addr = 16'h0; size = 2'b00;
    repeat (3) @(posedge clk);
    #1 check("R8 in reset", irq, ign, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; es = 1'b0;
    repeat (4) @(posedge clk);
    #1 check("R8 after release", irq, ign, 1'b0, 1'b0);

    step(0, 0, 0, 16'h0000, 2'b00, 0, 0, "R8 idle");
    step(1, 1, 0, 16'h0000, 2'b00, 0, 0, "R1 native mode");
    step(1, 1, 0, 16'h0000, 2'b00, 0, 0, "R1 native hold");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R2 raise");
    step(0, 1, 1, 16'h00F2, 2'b00, 1, 0, "R7 other port");
    step(0, 1, 1, 16'h00F0, 2'b01, 1, 0, "R7 word write");
    step(0, 1, 1, 16'h01F1, 2'b00, 1, 0, "R3 high addr bits");
    step(0, 1, 1, 16'h00F1, 2'b00, 0, 1, "R4 ack F1");
    step(0, 1, 0, 16'h0000, 2'b00, 0, 1, "R5 mute hold");
    step(0, 1, 1, 16'h00F0, 2'b00, 0, 1, "R5 second ack");
    step(0, 0, 0, 16'h0000, 2'b00, 0, 0, "R6 es clears");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R6 monitor resumes");
    step(0, 0, 0, 16'h0000, 2'b00, 0, 0, "R9 es drop unacked");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R2 raise again");
    step(1, 1, 0, 16'h0000, 2'b00, 0, 0, "R1 native withdraws");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R2 raise third");
    step(0, 1, 1, 16'h00F0, 2'b00, 0, 1, "R3 ack F0");
    step(1, 1, 0, 16'h0000, 2'b00, 0, 1, "R5 ne change muted");
    step(1, 0, 0, 16'h0000, 2'b00, 0, 0, "R6 exit with ne");
    step(0, 0, 1, 16'h00F0, 2'b00, 0, 0, "R7 ack while idle");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R7 idle ack inert");
    step(0, 1, 1, 16'h00F1, 2'b10, 1, 0, "R7 dword write");
    step(0, 1, 0, 16'h0000, 2'b00, 1, 0, "R2 stays raised");
    step(0, 0, 0, 16'h0000, 2'b00, 0, 0, "R9 final drop");

    @(negedge clk);
    wr = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule